// File: doc/BRIEF.md
# I2C Slave Data-Phase Sequencer

This block runs the byte-level part of an I2C slave once an external address decoder has recognised the slave. It takes synchronised SCL edge strobes, the synchronised SDA level and START/STOP strobes from the bus front end. It shifts bytes in or out most significant bit first, and generates or checks the acknowledge bit in the ninth clock slot. It also decides when the ninth slot must be stretched by holding SCL low.

The host or DMA side sees one transmit holding register and one receive holding register. Each sits in front of its own shift register, so the next byte can be prepared while the current one moves on the wire. The matched address is always kept in an address status register. A configuration bit can also put it into the receive holding register. A second configuration bit chooses when transmit data is requested: whenever the holding register is empty, or only while a slave-transmit transfer is running.

A transfer ends on a master NACK unless that is overridden. It also ends when the level the slave drives differs from the level sampled on SDA, or when START or STOP is seen. Stretching in the ninth slot is enabled separately for the address byte, transmit bytes and receive bytes.

Top module: `i2c_slave_xfer`

## Requirements
- R1: On `match_stb` the block sets `addr_valid` and captures `match_addr` into `addr_data`. At the next SCL fall it pulls SDA low (`sda_low`=1) for the address acknowledge slot. `addr_rd` clears `addr_valid`.
- R2: With `cfg_addr_in_rx`=1 a match also writes the address into `rx_data` and sets `rx_valid`. With it at 0, `rx_valid` is left unchanged by the match.
- R3: In receive mode (`match_rw`=0), SDA is sampled on each SCL rise, MSB first. On the eighth rise the byte moves to `rx_data` and `rx_valid` is set. The following SCL fall pulls SDA low as the acknowledge.
- R4: If `rx_valid` is still set when a received byte completes, `rx_data` keeps its old value and the slave releases SDA in that byte's acknowledge slot (NACK).
- R5: In transmit mode (`match_rw`=1), the holding register is moved to the shifter at the SCL fall that starts the first bit. `sda_low` is the inverse of the current bit, MSB first, and changes only on SCL falls. An empty holding register sends all ones.
- R6: `tx_req` is 1 when the holding register is empty and either `cfg_tx_early`=1 or a transmit transfer is active. `tx_wr` is accepted only while `tx_req`=1. Otherwise it is ignored.
- R7: A high SDA sampled in the acknowledge slot of a transmitted data byte ends the transfer, unless `cfg_ignore_nack`=1.
- R8: When SDA is sampled on an SCL rise at a level other than the one the slave drives, `bit_err` is set and the transfer ends with SDA released. The next match clears `bit_err`.
- R9: `start_det` or `stop_det` ends the current transfer at once and releases SDA. Later SCL edges have no effect until the next match.
- R10: With `cfg_stretch_addr`=1, `scl_low` is held during the low phase of the address acknowledge slot while `addr_valid`=1. It is released by `addr_rd`.
- R11: With `cfg_stretch_tx`=1, `scl_low` is held in the acknowledge slot of a transmit transfer while the holding register is empty. It is released by `tx_wr`.
- R12: With `cfg_stretch_rx`=1, `scl_low` is held in the acknowledge slot of a received data byte while `rx_valid`=1. It is released by `rx_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_rise | input | 1 | One-cycle strobe on a synchronised SCL rising edge |
| scl_fall | input | 1 | One-cycle strobe on a synchronised SCL falling edge |
| sda_in | input | 1 | Synchronised SDA level |
| start_det | input | 1 | START or repeated START seen |
| stop_det | input | 1 | STOP seen |
| match_stb | input | 1 | Address matched, given while SCL is high after the eighth address bit |
| match_rw | input | 1 | Direction of the match: 1 = slave transmits |
| match_addr | input | 8 | Matched address byte |
| cfg_ignore_nack | input | 1 | Keep transmitting after a NACK |
| cfg_addr_in_rx | input | 1 | Also deliver the address through the receive register |
| cfg_tx_early | input | 1 | Request transmit data whenever the holding register is empty |
| cfg_stretch_addr | input | 1 | Stretch the address acknowledge slot |
| cfg_stretch_tx | input | 1 | Stretch the transmit acknowledge slot |
| cfg_stretch_rx | input | 1 | Stretch the receive acknowledge slot |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 8 | Transmit write data |
| rx_rd | input | 1 | Read strobe, clears `rx_valid` |
| addr_rd | input | 1 | Read strobe, clears `addr_valid` |
| sda_low | output | 1 | Pull SDA low |
| scl_low | output | 1 | Pull SCL low (stretch) |
| tx_req | output | 1 | Transmit data request |
| rx_data | output | 8 | Receive holding register |
| rx_valid | output | 1 | Receive data flag |
| addr_valid | output | 1 | Address valid flag |
| addr_data | output | 8 | Address status register |
| bit_err | output | 1 | SDA mismatch flag |

## Verification
The bench aims at the receive overrun. A design that overwrote the unread byte, or that still acknowledged it, would show a changed `rx_data` or a low `sda_low` in that slot. It drives a NACK both with and without the override. A sequencer that ignored the NACK would keep `tx_req` high after the transfer should have ended, and one that ignored the override would drop it. It forces an SDA mismatch on a released bit, which must raise `bit_err` and stop the slave from driving. It also checks that each stretch case holds SCL only until its own host action, so a wrongly gated stretch would either never appear or never release.

// File: rtl/i2c_slx_pkg.sv
// Shared types for the I2C slave data-phase sequencer.
package i2c_slx_pkg;
    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_RX   = 2'd1,
        XF_TX   = 2'd2
    } xfer_mode_e;
endpackage

// File: rtl/i2c_slx_rxbuf.sv
// Receive path: shift register plus one holding register with a valid flag.
// Assumes shift_en pulses once per sampled bit and commit comes with the last
// shift of a byte. A byte that completes while the holder is full is dropped.
module i2c_slx_rxbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic              commit,
    input  logic              addr_load,
    input  logic [DATA_W-1:0] addr_byte,
    input  logic              rd,
    output logic [DATA_W-1:0] data,
    output logic              valid,
    output logic              took
);
    logic [DATA_W-1:0] sh_q;

    assign took = commit && !valid;

    // Shift in sampled bits and move finished bytes into the holder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            if (shift_en) sh_q <= {sh_q[DATA_W-2:0], bit_in};
            if (addr_load) begin
                data  <= addr_byte;
                valid <= 1'b1;
            end else if (took) begin
                data  <= {sh_q[DATA_W-2:0], bit_in};
                valid <= 1'b1;
            end else if (rd) begin
                valid <= 1'b0;
            end
        end
    end

    a_r4_hold_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && commit && !addr_load) |=> $stable(data));
    a_r3_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(commit || addr_load));
endmodule

// File: rtl/i2c_slx_txbuf.sv
// Transmit path: holding register with a full flag, feeding a shifter.
// Assumes load pulses at the start of each transmitted byte. An empty holder
// loads all ones, so the slave leaves SDA released.
module i2c_slx_txbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              wr_ok,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load,
    output logic              full,
    output logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] shift_q
);
    logic [DATA_W-1:0] hold_q;

    assign load_val = full ? hold_q : '1;

    // Accept host writes and hand the held byte to the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            full    <= 1'b0;
            shift_q <= '1;
        end else begin
            if (load) begin
                shift_q <= load_val;
                full    <= 1'b0;
            end
            if (wr && wr_ok) begin
                hold_q <= wdata;
                full   <= 1'b1;
            end
        end
    end

    a_r6_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wr_ok) |=> $stable(hold_q));
endmodule

// File: rtl/i2c_slx_stretch.sv
// Stretch decision: hold SCL low in the ninth-slot low phase while the
// enabled condition for this slot is pending. Purely combinational.
module i2c_slx_stretch (
    input  logic ack_low,
    input  logic addr_ph,
    input  logic is_tx,
    input  logic en_addr,
    input  logic en_tx,
    input  logic en_rx,
    input  logic addr_pending,
    input  logic tx_empty,
    input  logic rx_pending,
    output logic scl_low
);
    logic hold_addr, hold_tx, hold_rx;

    // Evaluate each of the three independently enabled cases.
    always_comb begin
        hold_addr = en_addr && addr_ph && addr_pending;
        hold_tx   = en_tx && is_tx && tx_empty;
        hold_rx   = en_rx && !is_tx && !addr_ph && rx_pending;
        scl_low   = ack_low && (hold_addr || hold_tx || hold_rx);
    end
endmodule

// File: rtl/i2c_slave_xfer.sv
// I2C slave data-phase sequencer. It starts on an address match strobe given
// while SCL is high after the eighth address bit. It counts bit slots on SCL
// falls, samples on SCL rises, and ends on NACK, SDA mismatch, START or STOP.
// Assumes edge strobes are single-cycle and never coincide with START/STOP.
module i2c_slave_xfer
    import i2c_slx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              match_stb,
    input  logic              match_rw,
    input  logic [DATA_W-1:0] match_addr,
    input  logic              cfg_ignore_nack,
    input  logic              cfg_addr_in_rx,
    input  logic              cfg_tx_early,
    input  logic              cfg_stretch_addr,
    input  logic              cfg_stretch_tx,
    input  logic              cfg_stretch_rx,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              rx_rd,
    input  logic              addr_rd,
    output logic              sda_low,
    output logic              scl_low,
    output logic              tx_req,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              addr_valid,
    output logic [DATA_W-1:0] addr_data,
    output logic              bit_err
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    xfer_mode_e        mode_q;
    logic [CNT_W-1:0]  cnt_q, cnt_nxt;
    logic              scl_hi_q, addr_ph_q, ack_ok_q, sda_low_q, bit_err_q;
    logic              addr_valid_q;
    logic [DATA_W-1:0] addr_data_q;
    logic              active, is_rx, is_tx, abort, quiet;
    logic              rx_shift, rx_commit, rx_took, addr_load, tx_load;
    logic              tx_full, tx_bit;
    logic [DATA_W-1:0] tx_load_val, tx_shift_q, bit_src;
    logic [IDX_W-1:0]  bit_idx;

    // Decode mode and the per-edge datapath strobes.
    always_comb begin
        active    = mode_q != XF_IDLE;
        is_rx     = mode_q == XF_RX;
        is_tx     = mode_q == XF_TX;
        abort     = start_det || stop_det;
        quiet     = !abort && !match_stb;
        rx_shift  = is_rx && scl_rise && quiet && (cnt_q < ACK_SLOT);
        rx_commit = rx_shift && (cnt_q == LAST_BIT);
        tx_load   = is_tx && scl_fall && quiet && (cnt_q == ACK_SLOT);
        addr_load = match_stb && !abort && cfg_addr_in_rx;
        cnt_nxt   = (cnt_q == ACK_SLOT) ? '0 : cnt_q + 1'b1;
        bit_src   = tx_load ? tx_load_val : tx_shift_q;
        bit_idx   = IDX_W'(DATA_W - 1) - IDX_W'(cnt_nxt);
        tx_bit    = bit_src[bit_idx];
        tx_req    = !tx_full && (cfg_tx_early || is_tx);
    end

    // Transfer sequencer: slot counter, SDA drive, acknowledge and end rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q       <= XF_IDLE;
            cnt_q        <= '0;
            scl_hi_q     <= 1'b1;
            addr_ph_q    <= 1'b0;
            ack_ok_q     <= 1'b0;
            sda_low_q    <= 1'b0;
            bit_err_q    <= 1'b0;
            addr_valid_q <= 1'b0;
            addr_data_q  <= '0;
        end else begin
            if (addr_rd) addr_valid_q <= 1'b0;
            if (abort) begin
                mode_q    <= XF_IDLE;
                sda_low_q <= 1'b0;
            end else if (match_stb) begin
                mode_q       <= match_rw ? XF_TX : XF_RX;
                cnt_q        <= LAST_BIT;
                scl_hi_q     <= 1'b1;
                addr_ph_q    <= 1'b1;
                ack_ok_q     <= 1'b1;
                sda_low_q    <= 1'b0;
                bit_err_q    <= 1'b0;
                addr_valid_q <= 1'b1;
                addr_data_q  <= match_addr;
            end else begin
                if (scl_rise) scl_hi_q <= 1'b1;
                if (scl_fall) scl_hi_q <= 1'b0;
                if (active && scl_fall) begin
                    cnt_q <= cnt_nxt;
                    if (cnt_q == LAST_BIT) begin
                        sda_low_q <= (is_rx || addr_ph_q) ? ack_ok_q : 1'b0;
                    end else begin
                        if (cnt_q == ACK_SLOT) addr_ph_q <= 1'b0;
                        sda_low_q <= is_tx ? !tx_bit : 1'b0;
                    end
                end
                if (active && scl_rise) begin
                    if (cnt_q == ACK_SLOT) begin
                        if (sda_low_q && sda_in) begin
                            bit_err_q <= 1'b1;
                            mode_q    <= XF_IDLE;
                            sda_low_q <= 1'b0;
                        end else if (is_tx && !addr_ph_q && sda_in && !cfg_ignore_nack) begin
                            mode_q    <= XF_IDLE;
                            sda_low_q <= 1'b0;
                        end
                    end else begin
                        if (rx_commit) ack_ok_q <= rx_took;
                        if (is_tx && (sda_in == sda_low_q)) begin
                            bit_err_q <= 1'b1;
                            mode_q    <= XF_IDLE;
                            sda_low_q <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    i2c_slx_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (rx_shift),
        .bit_in    (sda_in),
        .commit    (rx_commit),
        .addr_load (addr_load),
        .addr_byte (match_addr),
        .rd        (rx_rd),
        .data      (rx_data),
        .valid     (rx_valid),
        .took      (rx_took)
    );

    i2c_slx_txbuf #(.DATA_W(DATA_W)) u_txbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (tx_wr),
        .wr_ok    (tx_req),
        .wdata    (tx_wdata),
        .load     (tx_load),
        .full     (tx_full),
        .load_val (tx_load_val),
        .shift_q  (tx_shift_q)
    );

    i2c_slx_stretch u_stretch (
        .ack_low      (active && (cnt_q == ACK_SLOT) && !scl_hi_q),
        .addr_ph      (addr_ph_q),
        .is_tx        (is_tx),
        .en_addr      (cfg_stretch_addr),
        .en_tx        (cfg_stretch_tx),
        .en_rx        (cfg_stretch_rx),
        .addr_pending (addr_valid_q),
        .tx_empty     (!tx_full),
        .rx_pending   (rx_valid),
        .scl_low      (scl_low)
    );

    assign sda_low    = sda_low_q;
    assign bit_err    = bit_err_q;
    assign addr_valid = addr_valid_q;
    assign addr_data  = addr_data_q;

    a_r5_sda_set_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low_q) |-> $past(scl_fall));
    a_r9_release_on_cond: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> !sda_low_q);
    a_r8_err_releases: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_err_q) |-> (!sda_low_q && mode_q == XF_IDLE));
    a_r11_no_rise_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        scl_low |-> !scl_rise);
endmodule

// File: tb/i2c_slave_xfer_bench.sv
module i2c_slave_xfer_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_rise = 0, scl_fall = 0, sda_in = 1, start_det = 0, stop_det = 0;
    logic match_stb = 0, match_rw = 0;
    logic [7:0] match_addr = '0, tx_wdata = '0;
    logic cfg_ignore_nack = 0, cfg_addr_in_rx = 0, cfg_tx_early = 0;
    logic cfg_stretch_addr = 0, cfg_stretch_tx = 0, cfg_stretch_rx = 0;
    logic tx_wr = 0, rx_rd = 0, addr_rd = 0;
    logic sda_low, scl_low, tx_req, rx_valid, addr_valid, bit_err;
    logic [7:0] rx_data, addr_data;
    int n_chk = 0, n_err = 0;

    // Receive vectors: {read before, byte sent, expected ack, expected rx_data}
    localparam logic [17:0] RX_VEC [4] = '{
        {1'b0, 8'hA5, 1'b1, 8'hA5},
        {1'b1, 8'h3C, 1'b1, 8'h3C},
        {1'b0, 8'h77, 1'b0, 8'h3C},
        {1'b1, 8'h0F, 1'b1, 8'h0F}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_slave_xfer u_i2c_slave_xfer (.*);

    task automatic step(); @(negedge clk); endtask
    task automatic rise(); scl_rise = 1; step(); scl_rise = 0; endtask
    task automatic fall(); scl_fall = 1; step(); scl_fall = 0; endtask
    task automatic pulse_rd(); rx_rd = 1; step(); rx_rd = 0; endtask
    task automatic pulse_ar(); addr_rd = 1; step(); addr_rd = 0; endtask
    task automatic write_tx(input logic [7:0] b);
        tx_wdata = b; tx_wr = 1; step(); tx_wr = 0;
    endtask
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask
    // START, eighth address rise, then the match strobe
    task automatic begin_xfer(input logic rw, input logic [7:0] a);
        start_det = 1; step(); start_det = 0;
        rise();
        match_rw = rw; match_addr = a; match_stb = 1; step(); match_stb = 0;
    endtask
    task automatic rx_byte(input logic [7:0] b);
        for (int k = 7; k >= 0; k--) begin
            sda_in = b[k]; rise(); fall();
        end
    endtask
    task automatic ack_pass(); sda_in = !sda_low; rise(); fall(); endtask
    task automatic tx_byte(input logic [7:0] b);
        for (int k = 7; k >= 0; k--) begin
            check("R5 bit drive", sda_low, !b[k]);
            sda_in = b[k]; rise(); fall();
        end
    endtask
    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst_n = 1; step();
        check("R6 reset tx_req", tx_req, 0);
        check("R1 reset flags", {sda_low, scl_low, rx_valid, addr_valid, bit_err}, 0);

        // Receive table (R1, R2, R3, R4)
        begin_xfer(0, 8'h2A);
        check("R1 addr_valid", addr_valid, 1);
        check("R1 addr_data", addr_data, 8'h2A);
        check("R2 rx untouched", rx_valid, 0);
        fall();
        check("R1 address ack", sda_low, 1);
        ack_pass();
        for (int i = 0; i < 4; i++) begin
            if (RX_VEC[i][17]) pulse_rd();
            rx_byte(RX_VEC[i][16:9]);
            check("R3/R4 ack slot", sda_low, RX_VEC[i][8]);
            check("R3/R4 rx_data", rx_data, RX_VEC[i][7:0]);
            check("R3 rx_valid", rx_valid, 1);
            ack_pass();
        end
        stop_det = 1; step(); stop_det = 0;
        check("R9 stop releases", sda_low, 0);
        pulse_rd(); pulse_ar();
        check("R1 addr_rd clears", addr_valid, 0);
        rx_byte(8'h99);
        check("R9 edges ignored after stop", rx_valid, 0);

        // Transmit with double buffer and NACK end (R2, R5, R6, R7)
        write_tx(8'h55);
        cfg_addr_in_rx = 1;
        begin_xfer(1, 8'h4B);
        check("R2 address in rx", rx_data, 8'h4B);
        check("R2 rx_valid by match", rx_valid, 1);
        check("R6 idle write ignored", tx_req, 1);
        write_tx(8'hC3);
        check("R6 full drops request", tx_req, 0);
        fall();
        check("R1 read address ack", sda_low, 1);
        sda_in = 0; rise(); fall();
        check("R5 holder moved to shifter", tx_req, 1);
        write_tx(8'h5A);
        tx_byte(8'hC3);
        check("R5 released for master ack", sda_low, 0);
        sda_in = 0; rise(); fall();
        tx_byte(8'h5A);
        sda_in = 1; rise();
        check("R7 NACK ends transfer", tx_req, 0);
        fall();
        check("R7 SDA released after NACK", sda_low, 0);

        // Ignored NACK and underflow (R5, R7)
        cfg_ignore_nack = 1; cfg_addr_in_rx = 0; pulse_rd();
        begin_xfer(1, 8'h4B);
        fall(); sda_in = 0; rise(); fall();
        tx_byte(8'hFF);
        sda_in = 1; rise();
        check("R7 NACK override keeps transfer", tx_req, 1);
        fall();
        check("R5 underflow sends ones", sda_low, 0);
        stop_det = 1; step(); stop_det = 0;
        cfg_ignore_nack = 0;

        // Bit error (R8)
        begin_xfer(1, 8'h4B);
        write_tx(8'h40);
        fall(); sda_in = 0; rise(); fall();
        check("R5 bit7 of 40", sda_low, 1);
        sda_in = 0; rise(); fall();
        check("R5 bit6 of 40", sda_low, 0);
        sda_in = 0; rise();
        check("R8 bit_err set", bit_err, 1);
        check("R8 SDA released", sda_low, 0);
        check("R8 transfer ended", tx_req, 0);
        fall();

        // Address and receive stretching (R10, R12)
        cfg_stretch_addr = 1; cfg_stretch_rx = 1; pulse_ar();
        begin_xfer(0, 8'h12);
        check("R8 match clears bit_err", bit_err, 0);
        fall();
        repeat (3) step();
        check("R10 address stretch held", scl_low, 1);
        pulse_ar();
        check("R10 released by addr_rd", scl_low, 0);
        sda_in = 0; rise(); fall();
        rx_byte(8'h11);
        check("R12 receive stretch held", scl_low, 1);
        pulse_rd();
        check("R12 released by rx_rd", scl_low, 0);
        stop_det = 1; step(); stop_det = 0;
        cfg_stretch_addr = 0; cfg_stretch_rx = 0; pulse_ar();

        // Transmit stretching and early request (R11, R6)
        cfg_stretch_tx = 1;
        begin_xfer(1, 8'h4B);
        fall();
        check("R11 transmit stretch held", scl_low, 1);
        write_tx(8'h81);
        check("R11 released by tx_wr", scl_low, 0);
        sda_in = 0; rise(); fall();
        stop_det = 1; step(); stop_det = 0;
        cfg_stretch_tx = 0;
        check("R6 idle no request", tx_req, 0);
        cfg_tx_early = 1; step();
        check("R6 early request when empty", tx_req, 1);

        finish_run();
    end
endmodule